// File: doc/BRIEF.md
# Load Value Prediction Logging Cache

This block decides which load values a record-and-replay system must write to its log. It holds a small direct-indexed copy of data values, indexed by low address bits. Each memory operation from one thread presents an address and a value. For a load, the value is the one actually read from memory. For a store, it is the data being written. A load whose value equals the copy's prediction produces nothing. A load whose value differs is sent out on a log stream together with the thread's operation sequence number, and the copy entry takes the new value.

The replay side runs an identical copy that it updates by the same rules, so it can rebuild every value that was not logged. The copy has no tags and no valid bits, and it stores only data. Addresses that share an index therefore share a prediction. A mismatch is always caught, because the compare is against the real value.

Two events need explicit handling:
- Loads from time-sensitive or machine-identity instructions are marked with a force input and are always logged.
- A flush input models a system call or any other event where outside agents change memory. It returns every entry to zero.

Top module: `lvp_log_cache`

## Requirements
- R1: After reset `log_valid` is 0 and `in_ready` is 1 once the reset synchronizer has released. Every copy entry starts at zero, so a load that reads 0 produces no log entry.
- R2: An accepted load (`in_store`=0, `in_force`=0) whose `in_data` equals the copy entry at its index produces no log entry.
- R3: An accepted load whose `in_data` differs from the copy entry raises `log_valid` on the next cycle. `log_value` then equals `in_data`.
- R4: After a logged load, the entry at that index holds the loaded value. A following load of the same value at that index is not logged.
- R5: An accepted store (`in_store`=1) writes `in_data` into the entry at its index and never produces a log entry.
- R6: The copy index is address bits [OFF_W+IDX_W-1:OFF_W], with no tag compare. With the defaults this is bits [5:2], so addresses 64 bytes apart share one entry.
- R7: An accepted load with `in_force`=1 is logged even when it matches the copy, and it leaves the entry holding its value.
- R8: While `flush` is 1, `in_ready` is 0. A flush cycle sets every entry to zero.
- R9: While `log_valid` is 1 and `log_ready` is 0, `in_ready` is 0 and `log_value` and `log_seq` hold steady.
- R10: `log_seq` is the zero-based count of memory operations, loads and stores alike, accepted since reset before the logged load.
- R11: `in_force` has no effect on a store: no log entry is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear every copy entry to zero (outside memory change) |
| in_valid | input | 1 | Memory operation present |
| in_ready | output | 1 | Operation accepted on this edge when in_valid is 1 |
| in_store | input | 1 | 1 = store, 0 = load |
| in_force | input | 1 | Load comes from a special instruction; always log it |
| in_addr | input | AW | Byte address of the operation |
| in_data | input | DW | Value read (load) or written (store) |
| log_valid | output | 1 | Log entry available |
| log_ready | input | 1 | Log consumer takes the entry |
| log_seq | output | CW | Sequence number of the logged load |
| log_value | output | DW | Logged load value |

## Verification
A corrupt copy entry shows up only when a later load maps to that index. It then appears at the port as an extra log entry, or as a missing one, one cycle after that load is accepted. A wrong sequence counter corrupts `log_seq` on every later log entry. A broken stall shows up as a lost entry or a changed payload while `log_ready` is held low. The bench therefore replays loads to each written index and to aliasing addresses, and it checks every emitted entry against a reference copy, in order.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  localparam int unsigned LVP_AW    = 32;
  localparam int unsigned LVP_DW    = 32;
  localparam int unsigned LVP_CW    = 32;
  localparam int unsigned LVP_IDX_W = 4;
  localparam int unsigned LVP_OFF_W = 2;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } lvp_op_e;
endpackage

// File: rtl/lvp_value_table.sv
module lvp_value_table #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DW-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic          ent_en;
    logic [DW-1:0] ent_d;

    always_comb begin
      ent_en = clr | (wr_en & (wr_idx == IDX_W'(g)));
      ent_d  = clr ? '0 : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (ent_en) begin
        ent_q[g] <= ent_d;
      end
    end
  end

  assign rd_data = ent_q[rd_idx];
endmodule

// File: rtl/lvp_seq_counter.sv
module lvp_seq_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/lvp_log_stage.sv
module lvp_log_stage #(
  parameter int unsigned CW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [CW-1:0] push_seq,
  input  logic [DW-1:0] push_value,
  output logic          can_take,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_seq,
  output logic [DW-1:0] out_value
);
  logic          vld_q, vld_d;
  logic [CW-1:0] seq_q;
  logic [DW-1:0] val_q;

  always_comb begin
    can_take = ~vld_q | out_ready;
    vld_d    = vld_q;
    if (push) begin
      vld_d = 1'b1;
    end else if (out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
      val_q <= '0;
    end else if (push) begin
      seq_q <= push_seq;
      val_q <= push_value;
    end
  end

  assign out_valid = vld_q;
  assign out_seq   = seq_q;
  assign out_value = val_q;
endmodule

// File: rtl/lvp_log_cache.sv
module lvp_log_cache
  import lvp_pkg::*;
#(
  parameter int unsigned AW    = LVP_AW,
  parameter int unsigned DW    = LVP_DW,
  parameter int unsigned CW    = LVP_CW,
  parameter int unsigned IDX_W = LVP_IDX_W,
  parameter int unsigned OFF_W = LVP_OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_store,
  input  logic          in_force,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          log_valid,
  input  logic          log_ready,
  output logic [CW-1:0] log_seq,
  output logic [DW-1:0] log_value
);
  localparam int unsigned IDX_LO = OFF_W;
  localparam int unsigned IDX_HI = OFF_W + IDX_W - 1;

  // Reset synchronizer: asserts asynchronously, releases on the clock.
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic             arst_n;
  logic             stage_can_take;
  logic             accept;
  logic             is_load;
  logic             mismatch;
  logic             emit;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    pred;
  logic [CW-1:0]    seq_now;
  lvp_op_e          op;

  assign arst_n = rst_s2_q;

  always_comb begin
    op       = lvp_op_e'(in_store);
    idx      = in_addr[IDX_HI:IDX_LO];
    in_ready = arst_n & ~flush & stage_can_take;
    accept   = in_valid & in_ready;
    is_load  = (op == OP_LOAD);
    mismatch = (pred != in_data);
    emit     = accept & is_load & (mismatch | in_force);
  end

  lvp_value_table #(.IDX_W(IDX_W), .DW(DW)) u_table (
    .clk     (clk),
    .rst_n   (arst_n),
    .clr     (flush),
    .wr_en   (accept),
    .wr_idx  (idx),
    .wr_data (in_data),
    .rd_idx  (idx),
    .rd_data (pred)
  );

  lvp_seq_counter #(.CW(CW)) u_seq (
    .clk   (clk),
    .rst_n (arst_n),
    .step  (accept),
    .count (seq_now)
  );

  lvp_log_stage #(.CW(CW), .DW(DW)) u_stage (
    .clk        (clk),
    .rst_n      (arst_n),
    .push       (emit),
    .push_seq   (seq_now),
    .push_value (in_data),
    .can_take   (stage_can_take),
    .out_valid  (log_valid),
    .out_ready  (log_ready),
    .out_seq    (log_seq),
    .out_value  (log_value)
  );
endmodule

// File: rtl/lvp_log_cache_chk.sv
module lvp_log_cache_chk #(
  parameter int unsigned CW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_store,
  input logic          in_force,
  input logic [DW-1:0] in_data,
  input logic          log_valid,
  input logic          log_ready,
  input logic [CW-1:0] log_seq,
  input logic [DW-1:0] log_value
);
  logic take_load, take_store;
  assign take_load  = in_valid & in_ready & ~in_store;
  assign take_store = in_valid & in_ready & in_store;

  p_flush_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  p_bp_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_ready) |-> !in_ready);

  p_bp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_ready) |=> (log_valid && $stable(log_value) && $stable(log_seq)));

  p_store_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_store |=> !log_valid);

  p_forced_log_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_load && in_force) |=> (log_valid && log_value == $past(in_data)));

  p_log_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_load |=> (!log_valid || log_value == $past(in_data)));
endmodule

bind lvp_log_cache lvp_log_cache_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_store  (in_store),
  .in_force  (in_force),
  .in_data   (in_data),
  .log_valid (log_valid),
  .log_ready (log_ready),
  .log_seq   (log_seq),
  .log_value (log_value)
);

// File: tb/lvp_log_cache_tb.sv
module lvp_log_cache_tb;
  localparam int AW = 32, DW = 32, CW = 32, IDX_W = 4, OFF_W = 2;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_store = 1'b0;
  logic in_force = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic log_ready = 1'b1;
  logic in_ready, log_valid;
  logic [CW-1:0] log_seq;
  logic [DW-1:0] log_value;

  always #2 clk = ~clk;

  lvp_log_cache u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_store(in_store),
    .in_force(in_force), .in_addr(in_addr), .in_data(in_data),
    .log_valid(log_valid), .log_ready(log_ready),
    .log_seq(log_seq), .log_value(log_value)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mdl [DEPTH];
  int unsigned seq = 0;
  bit bp_en = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  bit done = 1'b0;

  int unsigned   q_seq[$];
  logic [DW-1:0] q_val[$];
  string         q_tag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ix(input logic [AW-1:0] a);
    return int'(a[OFF_W+IDX_W-1:OFF_W]);
  endfunction

  // Backpressure pattern, updated after each edge.
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    log_ready <= bp_en ? lfsr[0] : 1'b1;
  end

  // Monitor: compares each handshaken log entry against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && log_valid && !log_ready)
      check(in_ready == 1'b0, "R9", "in_ready during backpressure", in_ready, 0);
    if (rst_n && flush)
      check(in_ready == 1'b0, "R8", "in_ready during flush", in_ready, 0);
    if (rst_n && log_valid && log_ready) begin
      if (q_val.size() == 0) begin
        check(1'b0, "R2", "unexpected log entry value", log_value, 0);
      end else begin
        automatic int unsigned es = q_seq.pop_front();
        automatic logic [DW-1:0] ev = q_val.pop_front();
        automatic string t = q_tag.pop_front();
        check(log_value == ev, t, "log_value", log_value, ev);
        check(log_seq == es, "R10", "log_seq", log_seq, es);
      end
    end
  end

  task automatic op(input bit st, input bit frc, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_store = st; in_force = frc; in_addr = a; in_data = d;
    while (!in_ready) @(negedge clk);
    if (!st && (frc || mdl[ix(a)] != d)) begin
      q_seq.push_back(seq); q_val.push_back(d); q_tag.push_back(tag);
    end
    mdl[ix(a)] = d;
    seq++;
    @(posedge clk);
    in_valid <= 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    flush <= 1'b0;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && q_val.size() != 0; i++) @(negedge clk);
    check(q_val.size() == 0, "R3", "missing log entries", q_val.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    repeat (4) @(negedge clk);
    check(log_valid == 1'b0, "R1", "log_valid after reset", log_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    op(0, 0, 32'h0000_0000, 32'h0, "R1");
    op(0, 0, 32'h0000_0034, 32'h0, "R1");
    op(0, 0, 32'h0000_0010, 32'h5, "R3");
    op(0, 0, 32'h0000_0010, 32'h5, "R4");
    op(0, 0, 32'h0000_0010, 32'h5, "R2");
    op(1, 0, 32'h0000_0020, 32'h7, "R5");
    op(0, 0, 32'h0000_0020, 32'h7, "R5");
    op(0, 0, 32'h0000_0020, 32'h8, "R3");
    op(1, 0, 32'h0000_0024, 32'h9, "R6");
    op(0, 0, 32'h0000_0064, 32'h9, "R6");
    op(0, 0, 32'h0000_1064, 32'h3, "R6");
    op(0, 1, 32'h0000_0010, 32'h5, "R7");
    op(0, 0, 32'h0000_0010, 32'h5, "R7");
    op(1, 1, 32'h0000_0030, 32'hab, "R11");
    op(0, 0, 32'h0000_0030, 32'hab, "R11");
    drain();

    do_flush();
    op(0, 0, 32'h0000_0010, 32'h0, "R8");
    op(0, 0, 32'h0000_0020, 32'h8, "R8");
    drain();

    bp_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      automatic logic [AW-1:0] a = AW'((i * 7) % 40) << 2;
      automatic logic [DW-1:0] d = DW'((i * 13) % 5);
      op((i % 4) == 3, (i % 9) == 0, a, d, "R9");
      if (i == 30) do_flush();
    end
    bp_en = 1'b0;
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule